// File: doc/BRIEF.md
# Serial Register Port with Time Snapshot

This block is a two-wire serial slave that gives a host byte-wide read and write access to a 256-location register space. Timekeeping registers sit at the low addresses and general-purpose storage sits above them, but the register file itself lives outside this block. The port receives already-synchronized clock and data line samples. It drives only an open-drain style pull-low request for the data line. Toward the register file it presents a pointer, write data with a one-cycle write strobe, and a read-data input that the register file returns for the current pointer.

A write transfer sets the pointer with its first data byte, and every byte after that is stored at the pointer, which then advances. A read transfer streams bytes from the pointer until the host answers with a not-acknowledge. The block emits a one-cycle snapshot pulse on every START condition and whenever the pointer advances from the top address back to zero. The register file uses that pulse to copy the running time into the shadow copy that reads return, so a multi-byte read always sees a coherent time. If the clock line is held low for too long, the port abandons the transfer and returns to idle, and a byte that has not yet been acknowledged is dropped.

Top module: `tkp_i2c_port`

## Requirements
- R1: The port answers only the 7-bit device address 1101000 (parameter DEV_ADDR, default 7'h68). The eighth bit of the address byte selects the direction, 0 for write and 1 for read. On a match, the port pulls the data line low during the ninth clock.
- R2: In a write transfer, the first byte after the address is loaded into the pointer. Each later byte is committed on the rising clock edge of its acknowledge bit: wrStrobe is high for one cycle with wrData equal to the byte, and regPtr equals the target address during that cycle. The pointer is one higher in the next cycle.
- R3: Every START condition, including a repeated START, produces exactly one snapPulse cycle, one clock after the condition is seen.
- R4: The pointer wraps from FFh to 00h, in both read and write transfers. Each wrap produces one snapPulse cycle.
- R5: A read transfer returns rdData for the current pointer, most significant bit first, and advances the pointer after each byte. The transfer stops driving the bus when the host answers a byte with a not-acknowledge (data line high).
- R6: If the clock line stays low for TIMEOUT_CYCLES system clocks during a transfer, the port returns to idle and releases the data line. Any partly received byte is never written. Every clock-line edge restarts the count.
- R7: After an address that does not match, the port does not acknowledge, issues no write strobe and leaves the pointer unchanged until the next START or STOP.
- R8: A repeated START without an intervening STOP restarts address matching. A read may follow a pointer-setting write within one transfer this way.
- R9: The data-line pull request changes only while the clock line is low.
- R10: After reset, sdaPullLow, wrStrobe and snapPulse are low and regPtr is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized serial clock line sample |
| sdaIn | input | 1 | Synchronized serial data line sample |
| sdaPullLow | output | 1 | Request to pull the data line low |
| regPtr | output | PTR_W | Register pointer toward the register file |
| wrData | output | 8 | Byte to store at regPtr |
| wrStrobe | output | 1 | One-cycle write request |
| rdData | input | 8 | Shadow/register contents at regPtr |
| snapPulse | output | 1 | One-cycle request to copy live time into the shadow registers |

## Verification
The situations that are hardest to reach from the pins are the pointer wrap and the timeout. A wrap only happens after a transfer has placed the pointer at the top address. The stimulus therefore loads FEh or FFh as the pointer and then streams enough bytes, in a write and in a read, to cross zero, counting snapshot pulses along the way. For the timeout, the bench stops a data byte partway through with the clock held low for longer than the limit. It then checks that the target location is unchanged and that a fresh transfer afterwards still works.

// File: rtl/tkp_i2c_pkg.sv
package tkp_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } busState_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic incPtr;
    logic wrStb;
    logic ackDrive;
    logic releaseBus;
    logic loadTx;
    logic shiftTx;
    logic snapStart;
  } portStb_t;

endpackage

// File: rtl/tkp_i2c_ctrl.sv
module tkp_i2c_ctrl
  import tkp_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR       = 7'h68,
  parameter int         TIMEOUT_CYCLES = 4000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic [7:0] rxByte,
  output portStb_t stb
);

  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYCLES - 1);

  busState_e state, stateN;
  logic [3:0] bitCnt, bitN;
  logic rwBit, rwN;
  logic sclQ, sdaQ;
  logic pendInc;
  logic [TO_W-1:0] toCnt;

  logic sclRise, sclFall, startDet, stopDet, timeoutHit;

  assign sclRise    = !sclQ && sclIn;
  assign sclFall    = sclQ && !sclIn;
  assign startDet   = sclQ && sclIn && sdaQ && !sdaIn;
  assign stopDet    = sclQ && sclIn && !sdaQ && sdaIn;
  assign timeoutHit = (state != ST_IDLE) && !sclIn && (toCnt == TO_LAST);

  always_comb begin
    stb    = '0;
    stateN = state;
    bitN   = bitCnt;
    rwN    = rwBit;
    if (timeoutHit) begin
      stateN = ST_IDLE;
      bitN   = '0;
      stb.releaseBus = 1'b1;
    end else if (startDet) begin
      stateN = ST_ADDR;
      bitN   = '0;
      stb.releaseBus = 1'b1;
      stb.snapStart  = 1'b1;
    end else if (stopDet) begin
      stateN = ST_IDLE;
      bitN   = '0;
      stb.releaseBus = 1'b1;
    end else if (sclRise) begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (bitCnt < 4'd8) begin
            stb.shiftIn = 1'b1;
            bitN = bitCnt + 4'd1;
          end else if (bitCnt == 4'd8) begin
            bitN = 4'd9;
            if (state == ST_PTR)   stb.loadPtr = 1'b1;
            if (state == ST_WDATA) stb.wrStb   = 1'b1;
          end
        end
        ST_RDATA: begin
          if (bitCnt < 4'd8) begin
            bitN = bitCnt + 4'd1;
          end else if (bitCnt == 4'd8) begin
            stb.incPtr = 1'b1;
            if (sdaIn) stateN = ST_SKIP;
            else       bitN   = 4'd9;
          end
        end
        default: ;
      endcase
    end else if (sclFall) begin
      unique case (state)
        ST_ADDR: begin
          if (bitCnt == 4'd8) begin
            if (rxByte[7:1] == DEV_ADDR) begin
              stb.ackDrive = 1'b1;
              rwN = rxByte[0];
            end else begin
              stateN = ST_SKIP;
            end
          end else if (bitCnt == 4'd9) begin
            bitN = '0;
            if (rwBit) begin
              stateN = ST_RDATA;
              stb.loadTx = 1'b1;
            end else begin
              stateN = ST_PTR;
              stb.releaseBus = 1'b1;
            end
          end
        end
        ST_PTR, ST_WDATA: begin
          if (bitCnt == 4'd8) begin
            stb.ackDrive = 1'b1;
          end else if (bitCnt == 4'd9) begin
            bitN   = '0;
            stateN = ST_WDATA;
            stb.releaseBus = 1'b1;
          end
        end
        ST_RDATA: begin
          if (bitCnt >= 4'd1 && bitCnt <= 4'd7) begin
            stb.shiftTx = 1'b1;
          end else if (bitCnt == 4'd8) begin
            stb.releaseBus = 1'b1;
          end else if (bitCnt == 4'd9) begin
            stb.loadTx = 1'b1;
            bitN = '0;
          end
        end
        default: ;
      endcase
    end
    // pointer advance one cycle after a committed write
    if (pendInc) stb.incPtr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      rwBit   <= 1'b0;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
      pendInc <= 1'b0;
      toCnt   <= '0;
    end else begin
      state   <= stateN;
      bitCnt  <= bitN;
      rwBit   <= rwN;
      sclQ    <= sclIn;
      sdaQ    <= sdaIn;
      pendInc <= stb.wrStb;
      if (state == ST_IDLE || sclIn || timeoutHit) toCnt <= '0;
      else                                         toCnt <= toCnt + 1'b1;
    end
  end

endmodule

// File: rtl/tkp_i2c_dpath.sv
module tkp_i2c_dpath
  import tkp_i2c_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaIn,
  input  portStb_t         stb,
  input  logic [7:0]       rdData,
  output logic [7:0]       rxByte,
  output logic [PTR_W-1:0] regPtr,
  output logic [7:0]       wrData,
  output logic             wrStrobe,
  output logic             snapPulse,
  output logic             sdaPullLow
);

  localparam logic [PTR_W-1:0] PTR_TOP = '1;

  logic [7:0] rxShift, txShift;

  assign rxByte = rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      regPtr     <= '0;
      wrData     <= '0;
      wrStrobe   <= 1'b0;
      snapPulse  <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaIn};

      if (stb.loadPtr)     regPtr <= rxShift[PTR_W-1:0];
      else if (stb.incPtr) regPtr <= regPtr + 1'b1;

      wrStrobe <= stb.wrStb;
      if (stb.wrStb) wrData <= rxShift;

      snapPulse <= stb.snapStart || (stb.incPtr && regPtr == PTR_TOP);

      if (stb.releaseBus) begin
        sdaPullLow <= 1'b0;
      end else if (stb.ackDrive) begin
        sdaPullLow <= 1'b1;
      end else if (stb.loadTx) begin
        txShift    <= rdData;
        sdaPullLow <= !rdData[7];
      end else if (stb.shiftTx) begin
        txShift    <= {txShift[6:0], 1'b0};
        sdaPullLow <= !txShift[6];
      end
    end
  end

endmodule

// File: rtl/tkp_i2c_port.sv
module tkp_i2c_port
  import tkp_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR       = 7'h68,
  parameter int         PTR_W          = 8,
  parameter int         TIMEOUT_CYCLES = 4000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaPullLow,
  output logic [PTR_W-1:0] regPtr,
  output logic [7:0]       wrData,
  output logic             wrStrobe,
  input  logic [7:0]       rdData,
  output logic             snapPulse
);

  portStb_t   stb;
  logic [7:0] rxByte;

  tkp_i2c_ctrl #(
    .DEV_ADDR       (DEV_ADDR),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (sclIn),
    .sdaIn  (sdaIn),
    .rxByte (rxByte),
    .stb    (stb)
  );

  tkp_i2c_dpath #(
    .PTR_W (PTR_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .sdaIn      (sdaIn),
    .stb        (stb),
    .rdData     (rdData),
    .rxByte     (rxByte),
    .regPtr     (regPtr),
    .wrData     (wrData),
    .wrStrobe   (wrStrobe),
    .snapPulse  (snapPulse),
    .sdaPullLow (sdaPullLow)
  );

endmodule

// File: rtl/tkp_i2c_port_chk.sv
module tkp_i2c_port_chk #(
  parameter int PTR_W          = 8,
  parameter int TIMEOUT_CYCLES = 4000
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaIn,
  input logic             sdaPullLow,
  input logic [PTR_W-1:0] regPtr,
  input logic             wrStrobe,
  input logic             snapPulse
);

  localparam int LW = $clog2(TIMEOUT_CYCLES + 3);
  localparam logic [LW-1:0] LOW_MAX = LW'(TIMEOUT_CYCLES + 2);

  logic sclD, sdaD;
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclD   <= 1'b1;
      sdaD   <= 1'b1;
      lowCnt <= '0;
    end else begin
      sclD <= sclIn;
      sdaD <= sdaIn;
      if (sclIn)                 lowCnt <= '0;
      else if (lowCnt < LOW_MAX) lowCnt <= lowCnt + 1'b1;
    end
  end

  // R3
  start_snap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclD && sclIn && sdaD && !sdaIn) |=> snapPulse);

  // R2
  write_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> (regPtr == $past(regPtr) + 1'b1));

  // R2
  write_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  // R9
  pull_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaPullLow));

  // R6
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lowCnt > LW'(TIMEOUT_CYCLES)) |-> !sdaPullLow);

endmodule

bind tkp_i2c_port tkp_i2c_port_chk #(
  .PTR_W          (PTR_W),
  .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sclIn      (sclIn),
  .sdaIn      (sdaIn),
  .sdaPullLow (sdaPullLow),
  .regPtr     (regPtr),
  .wrStrobe   (wrStrobe),
  .snapPulse  (snapPulse)
);

// File: tb/tkp_i2c_port_tb_top.sv
module tkp_i2c_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 4;
  localparam int TO_CYC     = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaBus;
  logic sdaPullLow, wrStrobe, snapPulse;
  logic [7:0] regPtr, wrData, rdData;
  logic [7:0] mem [256];
  int wrCount = 0;
  int snapCount = 0;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sdaBus = sdaM & ~sdaPullLow;
  assign rdData = mem[regPtr];

  tkp_i2c_port #(
    .DEV_ADDR       (7'h68),
    .PTR_W          (8),
    .TIMEOUT_CYCLES (TO_CYC)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaBus),
    .sdaPullLow (sdaPullLow),
    .regPtr     (regPtr),
    .wrData     (wrData),
    .wrStrobe   (wrStrobe),
    .rdData     (rdData),
    .snapPulse  (snapPulse)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
      wrCount   <= 0;
      snapCount <= 0;
    end else begin
      if (wrStrobe) begin
        mem[regPtr] <= wrData;
        wrCount     <= wrCount + 1;
      end
      if (snapPulse) snapCount <= snapCount + 1;
    end
  end

  task automatic checkVal(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; waitClks(QTR);
    sdaM = 1'b0; waitClks(QTR);
    sclM = 1'b0; waitClks(QTR);
  endtask

  task automatic busRestart();
    sdaM = 1'b1; waitClks(QTR);
    sclM = 1'b1; waitClks(QTR);
    sdaM = 1'b0; waitClks(QTR);
    sclM = 1'b0; waitClks(QTR);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitClks(QTR);
    sclM = 1'b1; waitClks(QTR);
    sdaM = 1'b1; waitClks(QTR);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; waitClks(QTR);
    sclM = 1'b1; waitClks(2*QTR);
    sclM = 1'b0; waitClks(QTR);
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; waitClks(QTR);
    sclM = 1'b1; waitClks(QTR);
    b = sdaBus; waitClks(QTR);
    sclM = 1'b0; waitClks(QTR);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(b);
    acked = !b;
  endtask

  task automatic getByte(input logic ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    sendBit(!ackIt);
  endtask

  task automatic testReset();
    checkVal("R10 pull", int'(sdaPullLow), 0);
    checkVal("R10 wrStrobe", int'(wrStrobe), 0);
    checkVal("R10 snap", int'(snapPulse), 0);
    checkVal("R10 ptr", int'(regPtr), 0);
  endtask

  task automatic testWrite();
    logic a;
    int w0;
    w0 = wrCount;
    busStart();
    sendByte(8'hD0, a); checkVal("R1 addr ack", int'(a), 1);
    sendByte(8'h20, a); checkVal("R2 ptr ack", int'(a), 1);
    sendByte(8'hA5, a);
    sendByte(8'h3C, a);
    busStop();
    checkVal("R2 mem20", int'(mem[8'h20]), 'hA5);
    checkVal("R2 mem21", int'(mem[8'h21]), 'h3C);
    checkVal("R2 ptr after", int'(regPtr), 'h22);
    checkVal("R2 write count", wrCount - w0, 2);
  endtask

  task automatic testReadRestart();
    logic a;
    logic [7:0] v;
    int s0;
    s0 = snapCount;
    busStart();
    sendByte(8'hD0, a);
    sendByte(8'h20, a);
    busRestart();
    sendByte(8'hD1, a); checkVal("R8 read addr ack", int'(a), 1);
    getByte(1'b1, v);   checkVal("R5 byte0", int'(v), 'hA5);
    getByte(1'b0, v);   checkVal("R5 byte1", int'(v), 'h3C);
    checkVal("R5 released after nack", int'(sdaPullLow), 0);
    busStop();
    checkVal("R5 ptr after", int'(regPtr), 'h22);
    checkVal("R3 snap per start", snapCount - s0, 2);
  endtask

  task automatic testMismatch();
    logic a;
    logic [7:0] v;
    int w0;
    w0 = wrCount;
    busStart();
    sendByte(8'hA0, a); checkVal("R7 no ack", int'(a), 0);
    sendByte(8'h10, a);
    sendByte(8'h77, a);
    busStop();
    checkVal("R7 no write", wrCount - w0, 0);
    checkVal("R7 mem10", int'(mem[8'h10]), 'h4A);
    checkVal("R7 ptr kept", int'(regPtr), 'h22);
    busStart();
    sendByte(8'hD1, a); checkVal("R7 recover ack", int'(a), 1);
    getByte(1'b0, v);   checkVal("R5 read at ptr", int'(v), 'h78);
    busStop();
  endtask

  task automatic testWriteWrap();
    logic a;
    int s0;
    s0 = snapCount;
    busStart();
    sendByte(8'hD0, a);
    sendByte(8'hFE, a);
    sendByte(8'h11, a);
    sendByte(8'h22, a);
    sendByte(8'h33, a);
    busStop();
    checkVal("R4 memFE", int'(mem[8'hFE]), 'h11);
    checkVal("R4 memFF", int'(mem[8'hFF]), 'h22);
    checkVal("R4 mem00", int'(mem[8'h00]), 'h33);
    checkVal("R4 ptr", int'(regPtr), 'h01);
    checkVal("R4 write wrap snap", snapCount - s0, 2);
  endtask

  task automatic testReadWrap();
    logic a;
    logic [7:0] v;
    int s0;
    s0 = snapCount;
    busStart();
    sendByte(8'hD0, a);
    sendByte(8'hFF, a);
    busRestart();
    sendByte(8'hD1, a);
    getByte(1'b1, v); checkVal("R4 readFF", int'(v), 'h22);
    getByte(1'b0, v); checkVal("R4 read00", int'(v), 'h33);
    busStop();
    checkVal("R4 read wrap snap", snapCount - s0, 3);
  endtask

  task automatic testTimeout();
    logic a;
    int w0;
    busStart();
    sendByte(8'hD0, a);
    sendByte(8'h40, a);
    w0 = wrCount;
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b0); sendBit(1'b1);
    sdaM = 1'b0;
    waitClks(TO_CYC + 20);
    checkVal("R6 released", int'(sdaPullLow), 0);
    sdaM = 1'b1; waitClks(QTR);
    sclM = 1'b1; waitClks(QTR);
    // more clocks that a stuck transfer would have turned into a byte
    sclM = 1'b0; waitClks(QTR);
    for (int i = 0; i < 5; i++) sendBit(1'b0);
    sdaM = 1'b1; waitClks(QTR);
    sclM = 1'b1; waitClks(QTR);
    checkVal("R6 no partial write", wrCount - w0, 0);
    checkVal("R6 mem40", int'(mem[8'h40]), 'h1A);
    busStart();
    sendByte(8'hD0, a); checkVal("R6 usable after", int'(a), 1);
    sendByte(8'h40, a);
    sendByte(8'h9C, a);
    busStop();
    checkVal("R6 write after", int'(mem[8'h40]), 'h9C);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : mainSeq
    waitClks(5);
    rstN = 1'b1;
    waitClks(3);
    testReset();
    testWrite();
    testReadRestart();
    testMismatch();
    testWriteWrap();
    testReadWrap();
    testTimeout();
    waitClks(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule